// File: doc/BRIEF.md
# Programmable AND-OR Logic Array

This block is the sum-of-products core of a small programmable logic device. Sixteen logic inputs, taken from dedicated pins and from macrocell feedback, are each presented to the array twice: once as the true value and once as the complement. That gives 32 array columns. Sixty-four product terms each AND together whichever columns their fuse row connects. The terms are split into eight groups of eight, and each group is ORed into one output sum.

Every product term has its own disable bit. A disabled term is forced low and never reaches a sum or an enable. Per output, a route bit can divert the group's first term so that it drives that output's enable instead of feeding the OR.

Configuration goes in through a simple synchronous write port. The fuse map is written one row per cycle. The disable bits and the route bits are each loaded in a single write. Sums and enables are registered, so they appear one clock after the inputs and configuration that produce them.

Top module: `pla_core`

## Requirements
- R1: Input i drives column 2i with its true value and column 2i+1 with its complement. Fuse bit c of a row set to 1 connects column c, and a term is the AND of all its connected columns.
- R2: Term row r belongs to output r/8 as its term number r%8. With the route bit clear, sum_out[o] is the OR of all eight terms of group o.
- R3: A disable bit r set to 1 forces term r to 0, so it contributes to neither its sum nor its enable. After a disable is set, a sum that term alone held high reads 0.
- R4: With route bit o set, term 0 of group o drives oe_out[o] and is left out of sum_out[o]. With route bit o clear, oe_out[o] is 1 and term 0 joins the OR.
- R5: A row that connects both the true and the complement column of any one input evaluates to 0.
- R6: A row with no connected columns evaluates to 1 unless its disable bit is set.
- R7: At a clock edge with fuse_we high, fuse_data is stored in row fuse_addr. At an edge with dis_we high, all disable bits load from dis_data. At an edge with route_we high, all route bits load from route_data.
- R8: sum_out and oe_out are registered. They take, one edge later, the values given by in_vec and the configuration present before that edge.
- R9: A synchronous reset clears sum_out and oe_out to 0, sets every disable bit, and clears every route bit. Fuse rows keep their contents through reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fuse_we | input | 1 | Fuse row write strobe |
| fuse_addr | input | 6 | Fuse row index |
| fuse_data | input | 32 | Fuse row contents, one bit per column |
| dis_we | input | 1 | Disable register load strobe |
| dis_data | input | 64 | Disable bits, one per term row |
| route_we | input | 1 | Route register load strobe |
| route_data | input | 8 | Route bits, one per output |
| in_vec | input | 16 | Logic inputs to the array |
| sum_out | output | 8 | Registered sums |
| oe_out | output | 8 | Registered enables |

## Verification
The assertions check several rules on every cycle:
- a contradictory row always evaluates low;
- an empty, enabled row always evaluates high;
- a routed group whose other seven terms are low gives a low sum;
- with every term disabled, the sums are zero;
- reset clears the outputs.

Other behaviour can only be shown by the bench's scenarios. These are the mapping of columns to inputs, the placement of rows within groups, the effect of individual writes, the one-cycle latency, and the fuse map surviving reset. The bench shows these with directed vectors and with random fuse maps, disable patterns and route settings, each compared with its own model.

// File: rtl/pla_pkg.sv
package pla_pkg;
  localparam int DEF_NUM_IN        = 16;
  localparam int DEF_NUM_OUT       = 8;
  localparam int DEF_TERMS_PER_OUT = 8;
endpackage

// File: rtl/pla_fuse_mem.sv
module pla_fuse_mem #(
  parameter int ROWS = 64,
  parameter int COLS = 32,
  localparam int AW = $clog2(ROWS)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AW-1:0]   addr,
  input  logic [COLS-1:0] wdata,
  output logic [COLS-1:0] rows [ROWS]
);
  logic [COLS-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  always_comb begin
    for (int r = 0; r < ROWS; r++) rows[r] = mem[r];
  end
endmodule

// File: rtl/pla_cfg_regs.sv
module pla_cfg_regs #(
  parameter int ROWS = 64,
  parameter int OUTS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            dis_we,
  input  logic [ROWS-1:0] dis_data,
  input  logic            route_we,
  input  logic [OUTS-1:0] route_data,
  output logic [ROWS-1:0] dis_q,
  output logic [OUTS-1:0] route_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dis_q   <= '1;
      route_q <= '0;
    end else begin
      if (dis_we)   dis_q   <= dis_data;
      if (route_we) route_q <= route_data;
    end
  end
endmodule

// File: rtl/pla_term_plane.sv
module pla_term_plane #(
  parameter int NUM_IN = 16,
  parameter int ROWS   = 64,
  localparam int COLS  = 2 * NUM_IN
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_IN-1:0] in_vec,
  input  logic [COLS-1:0]   fuse [ROWS],
  input  logic [ROWS-1:0]   dis,
  output logic [ROWS-1:0]   term
);
  localparam logic [COLS-1:0] TRUE_MASK = {NUM_IN{2'b01}};

  logic [COLS-1:0] cols;

  always_comb begin
    for (int i = 0; i < NUM_IN; i++) begin
      cols[2*i]   = in_vec[i];
      cols[2*i+1] = ~in_vec[i];
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic hit;
    always_comb begin
      hit = 1'b1;
      for (int c = 0; c < COLS; c++) begin
        if (fuse[r][c] && !cols[c]) hit = 1'b0;
      end
    end
    assign term[r] = hit & ~dis[r];

    AST_CONTRA_ZERO: assert property (@(posedge clk) disable iff (rst)
      (|(fuse[r] & (fuse[r] >> 1) & TRUE_MASK)) |-> !term[r]); // R5
    AST_EMPTY_ONE: assert property (@(posedge clk) disable iff (rst)
      ((fuse[r] == '0) && !dis[r]) |-> term[r]); // R6
  end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int NUM_OUT = 8,
  parameter int K       = 8,
  localparam int ROWS   = NUM_OUT * K
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ROWS-1:0]    term,
  input  logic [NUM_OUT-1:0] route,
  output logic [NUM_OUT-1:0] sum_c,
  output logic [NUM_OUT-1:0] oe_c
);
  localparam logic [K-1:0] REST_MASK = {{(K-1){1'b1}}, 1'b0};

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    logic [K-1:0] grp;
    logic [K-1:0] mask;
    assign grp     = term[o*K +: K];
    assign mask    = route[o] ? REST_MASK : '1;
    assign sum_c[o] = |(grp & mask);
    assign oe_c[o]  = route[o] ? grp[0] : 1'b1;

    AST_OE_EXCLUDED: assert property (@(posedge clk) disable iff (rst)
      (route[o] && ((grp & REST_MASK) == '0)) |-> !sum_c[o]); // R4
  end
endmodule

// File: rtl/pla_core.sv
module pla_core #(
  parameter int NUM_IN        = pla_pkg::DEF_NUM_IN,
  parameter int NUM_OUT       = pla_pkg::DEF_NUM_OUT,
  parameter int TERMS_PER_OUT = pla_pkg::DEF_TERMS_PER_OUT,
  localparam int COLS   = 2 * NUM_IN,
  localparam int ROWS   = NUM_OUT * TERMS_PER_OUT,
  localparam int ROW_AW = $clog2(ROWS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fuse_we,
  input  logic [ROW_AW-1:0]  fuse_addr,
  input  logic [COLS-1:0]    fuse_data,
  input  logic               dis_we,
  input  logic [ROWS-1:0]    dis_data,
  input  logic               route_we,
  input  logic [NUM_OUT-1:0] route_data,
  input  logic [NUM_IN-1:0]  in_vec,
  output logic [NUM_OUT-1:0] sum_out,
  output logic [NUM_OUT-1:0] oe_out
);
  logic [COLS-1:0]    fuse_rows [ROWS];
  logic [ROWS-1:0]    dis_q;
  logic [NUM_OUT-1:0] route_q;
  logic [ROWS-1:0]    term;
  logic [NUM_OUT-1:0] sum_c;
  logic [NUM_OUT-1:0] oe_c;

  pla_fuse_mem #(.ROWS(ROWS), .COLS(COLS)) u_mem (
    .clk(clk), .we(fuse_we), .addr(fuse_addr), .wdata(fuse_data), .rows(fuse_rows)
  );

  pla_cfg_regs #(.ROWS(ROWS), .OUTS(NUM_OUT)) u_cfg (
    .clk(clk), .rst(rst), .dis_we(dis_we), .dis_data(dis_data),
    .route_we(route_we), .route_data(route_data), .dis_q(dis_q), .route_q(route_q)
  );

  pla_term_plane #(.NUM_IN(NUM_IN), .ROWS(ROWS)) u_and (
    .clk(clk), .rst(rst), .in_vec(in_vec), .fuse(fuse_rows), .dis(dis_q), .term(term)
  );

  pla_or_plane #(.NUM_OUT(NUM_OUT), .K(TERMS_PER_OUT)) u_or (
    .clk(clk), .rst(rst), .term(term), .route(route_q), .sum_c(sum_c), .oe_c(oe_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_out <= '0;
      oe_out  <= '0;
    end else begin
      sum_out <= sum_c;
      oe_out  <= oe_c;
    end
  end

  AST_RST_CLEAR: assert property (@(posedge clk)
    rst |=> ((sum_out == '0) && (oe_out == '0))); // R9
  AST_ALL_DIS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (&dis_q) |=> (sum_out == '0)); // R3
endmodule

// File: tb/pla_core_tb_top.sv
module pla_core_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fuse_we = 1'b0;
  logic [5:0]  fuse_addr = '0;
  logic [31:0] fuse_data = '0;
  logic        dis_we = 1'b0;
  logic [63:0] dis_data = '0;
  logic        route_we = 1'b0;
  logic [7:0]  route_data = '0;
  logic [15:0] in_vec = '0;
  logic [7:0]  sum_out, oe_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] fm [64];
  logic [63:0] dism;
  logic [7:0]  routem;

  always #2 clk = ~clk;

  pla_core dut_i (
    .clk(clk), .rst(rst), .fuse_we(fuse_we), .fuse_addr(fuse_addr), .fuse_data(fuse_data),
    .dis_we(dis_we), .dis_data(dis_data), .route_we(route_we), .route_data(route_data),
    .in_vec(in_vec), .sum_out(sum_out), .oe_out(oe_out)
  );

  // in_vec, expected sum, expected enable for the directed configuration
  localparam logic [31:0] VEC [6] = '{
    {16'h0000, 8'h00, 8'h55},
    {16'h00FF, 8'h55, 8'hFF},
    {16'hFF00, 8'hFF, 8'h55},
    {16'h0F0F, 8'h0F, 8'h5F},
    {16'h3CA5, 8'h3D, 8'hF5},
    {16'h8001, 8'h81, 8'h55}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_row(input int r, input logic [31:0] d);
    @(negedge clk);
    fuse_we = 1'b1; fuse_addr = 6'(r); fuse_data = d;
    @(negedge clk);
    fuse_we = 1'b0;
    fm[r] = d;
  endtask

  task automatic wr_dis(input logic [63:0] d);
    @(negedge clk);
    dis_we = 1'b1; dis_data = d;
    @(negedge clk);
    dis_we = 1'b0;
    dism = d;
  endtask

  task automatic wr_route(input logic [7:0] d);
    @(negedge clk);
    route_we = 1'b1; route_data = d;
    @(negedge clk);
    route_we = 1'b0;
    routem = d;
  endtask

  function automatic void model(input logic [15:0] iv, output logic [7:0] s, output logic [7:0] e);
    logic [31:0] cv;
    logic [63:0] t;
    for (int i = 0; i < 16; i++) begin
      cv[2*i] = iv[i]; cv[2*i+1] = ~iv[i];
    end
    for (int r = 0; r < 64; r++) t[r] = ((fm[r] & ~cv) == 32'h0) && !dism[r];
    for (int o = 0; o < 8; o++) begin
      s[o] = 1'b0;
      for (int k = 0; k < 8; k++)
        if (!(k == 0 && routem[o])) s[o] = s[o] | t[o*8+k];
      e[o] = routem[o] ? t[o*8] : 1'b1;
    end
  endfunction

  task automatic apply(input logic [15:0] iv);
    @(negedge clk);
    in_vec = iv;
    @(negedge clk);
  endtask

  task automatic program_directed();
    logic [63:0] d;
    d = '1;
    for (int o = 0; o < 8; o++) begin
      wr_row(o*8,   32'h1 << (2*o));
      wr_row(o*8+1, 32'h1 << (2*(o+8)));
      for (int k = 2; k < 8; k++) wr_row(o*8+k, 32'h0);
      d[o*8] = 1'b0; d[o*8+1] = 1'b0;
    end
    wr_dis(d);
    wr_route(8'hAA);
  endtask

  initial begin
    logic [7:0] es, ee;
    dism = '1; routem = '0;
    repeat (3) @(negedge clk);
    check("R9 reset sum", sum_out, 8'h00);
    check("R9 reset oe", oe_out, 8'h00);
    rst = 1'b0;
    apply(16'hFFFF);
    check("R3 all disabled sum", sum_out, 8'h00);
    check("R4 no route oe", oe_out, 8'hFF);

    program_directed();
    for (int v = 0; v < 6; v++) begin
      apply(VEC[v][31:16]);
      check("R1 R2 R4 table sum", sum_out, VEC[v][15:8]);
      check("R4 table oe", oe_out, VEC[v][7:0]);
    end

    // R8: output holds until the edge after the input changes
    apply(16'h0000);
    @(negedge clk);
    in_vec = 16'hFF00;
    #1;
    check("R8 before edge", sum_out, 8'h00);
    @(negedge clk);
    check("R8 after edge", sum_out, 8'hFF);

    // R6: empty row 2 of output 0 enabled
    wr_row(2, 32'h0);
    wr_dis(dism & ~(64'h1 << 2));
    apply(16'h0000);
    check("R6 empty term sum", sum_out, 8'h01);
    // R5: same row connects true and complement of input 0
    wr_row(2, 32'h3);
    apply(16'h0000);
    check("R5 contradiction sum", sum_out, 8'h00);
    // R3: empty row again, now disabled
    wr_row(2, 32'h0);
    wr_dis(dism | (64'h1 << 2));
    apply(16'h0000);
    check("R3 disabled term sum", sum_out, 8'h00);
    // R4: routing off, term 0 of output 1 joins the sum
    wr_route(8'h00);
    apply(16'h0002);
    check("R4 unrouted sum", sum_out, 8'h02);
    check("R4 unrouted oe", oe_out, 8'hFF);
    // R7: one row rewritten changes only its output
    wr_row(3*8, 32'h2 << (2*3));
    apply(16'h0000);
    check("R7 row write sum", sum_out, 8'h08);

    // R9: reset keeps fuses, restores disables and routes
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R9 mid reset sum", sum_out, 8'h00);
    rst = 1'b0; dism = '1; routem = '0;
    apply(16'h00FF);
    check("R9 disables set sum", sum_out, 8'h00);
    check("R9 routes clear oe", oe_out, 8'hFF);
    wr_dis(64'h0303030303030303);
    wr_route(8'hAA);
    apply(16'h00FF);
    model(16'h00FF, es, ee);
    check("R9 fuses kept sum", sum_out, es);
    check("R9 fuses kept oe", oe_out, ee);

    // random configurations against the model
    for (int cfg = 0; cfg < 12; cfg++) begin
      for (int r = 0; r < 64; r++) wr_row(r, $urandom & $urandom & $urandom);
      wr_dis({$urandom, $urandom} & {$urandom, $urandom});
      wr_route(8'($urandom));
      for (int n = 0; n < 25; n++) begin
        logic [15:0] iv;
        iv = 16'($urandom);
        apply(iv);
        model(iv, es, ee);
        check("R1 R2 R3 random sum", sum_out, es);
        check("R4 random oe", oe_out, ee);
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule